// File: doc/BRIEF.md
# Two-Channel Time-of-Day Alarm and Interrupt Router

This block sits beside a BCD clock-calendar counter and decides when its two alarms go off. On every one-second update strobe it compares the current seconds, minutes, hours, weekday and day-of-month values with two programmable alarm sets. Alarm A holds four fields (second, minute, hour, day), and alarm B holds three (minute, hour, day). The top bit of each alarm field is a "don't care" mask, and the mask pattern sets the repeat rate. A match raises a sticky flag, which software clears by writing 0.

A control register sets two enables, a routing mode and a two-bit rate code. The flags reach two active-low, open-drain interrupt outputs, which are modelled as drive-low enables. In the default routing mode, both alarms share output A and output B carries a square wave derived from a 32.768 kHz reference. In the other mode, each alarm drives its own output. Software programs all registers through a simple synchronous write port. Alarm B has no seconds field, so it can only match at second 00.

Register addresses on `wr_addr`: 0 control, 1 status, 2 to 5 alarm A second/minute/hour/day, 6 to 8 alarm B minute/hour/day. Writes to any other address have no effect.

Top module: `alarm_irq_router`

## Requirements
- R1: After reset the control register is 0x18 and both flags are 0. The control bits are [4:3] rate code = 11, [2] routing mode = 0, [1] enable B = 0 and [0] enable A = 0. As a result, neither interrupt is driven and output B carries the fastest square wave.
- R2: Alarms are evaluated only in a cycle where `sec_tick` is 1. A matching flag reads 1 from the following clock edge. Matching time values without the strobe set nothing.
- R3: Alarm A uses mask bits (bit 7) in this order: day, hour, minute, second. The patterns are 1111 = every update, 1110 = second, 1100 = minute and second, 1000 = hour, minute and second, and 0000 = day or date plus hour, minute and second.
- R4: Alarm B fires only when the second is 00. Its masks, in the order day, hour, minute, are 111 = once per minute, 110 = minute, 100 = hour and minute, and 000 = day or date plus hour and minute.
- R5: Any mask pattern not listed in R3 or R4 never sets the flag, even when every field matches.
- R6: In a day register, bit 6 = 1 compares bits [2:0] with the weekday, and bit 6 = 0 compares bits [5:0] with the date.
- R7: Status register bits are [1] flag B and [0] flag A. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: An interrupt output is driven only when a flag and its enable are both 1. A flag with its enable at 0 drives nothing.
- R9: In routing mode 1, output A reflects alarm A only and output B reflects alarm B only.
- R10: In routing mode 0, output A is driven by either enabled flagged alarm, and output B is driven low while the square wave is low.
- R11: The rate codes 11, 10, 01 and 00 give a square wave at the reference rate, 1/4 of it, 1/8 of it, and 1/2^REF_LOG2 of it. With the default reference these are 32768, 8192, 4096 and 1 Hz.
- R12: Hours are compared on all seven value bits, including the 12/24 and AM/PM bits, with no format conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse marking the once-per-second time update |
| ref_clk_in | input | 1 | 32.768 kHz reference level, synchronous to clk |
| t_sec | input | 7 | Current seconds, BCD |
| t_min | input | 7 | Current minutes, BCD |
| t_hour | input | 7 | Current hours, BCD with format bits |
| t_wday | input | 3 | Current weekday 1..7 |
| t_date | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| alarm_flags | output | 2 | Sticky alarm flags {B, A} |
| irq_a_oe | output | 1 | Drive-low enable for interrupt output A |
| irq_b_oe | output | 1 | Drive-low enable for output B (interrupt or square wave) |

## Verification
Each mask pattern of alarm A is tried twice: once with time values that differ in exactly one compared field, and once with a full match. This separates a field that is correctly compared from one that is wrongly ignored. Alarm B is given non-zero seconds with otherwise matching fields, to show that the implicit second-00 rule applies. Invalid mask patterns are given completely matching fields, so that only the decode can keep them silent. Routing is checked with one flag and with both flags, each with enables on and off, under both modes. The four rate codes are told apart by counting square-wave periods over a fixed window.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    // Register addresses
    localparam logic [3:0] ADDR_CTRL    = 4'd0;
    localparam logic [3:0] ADDR_STATUS  = 4'd1;
    localparam logic [3:0] ADDR_AL_BASE = 4'd2;
    localparam int         AL_REGS      = 7;

    // Control reset: fastest rate, shared routing, interrupts off
    localparam logic [4:0] CTRL_RST = 5'h18;

    // Repeat behaviour selected by a mask pattern
    typedef enum logic [2:0] {
        RPT_EVERY,
        RPT_S,
        RPT_MS,
        RPT_HMS,
        RPT_FULL,
        RPT_NONE
    } rpt_e;

    // Mask order: {day, hour, minute, second}
    function automatic rpt_e decode_rpt(input logic [3:0] m);
        rpt_e r;
        case (m)
            4'b1111: r = RPT_EVERY;
            4'b1110: r = RPT_S;
            4'b1100: r = RPT_MS;
            4'b1000: r = RPT_HMS;
            4'b0000: r = RPT_FULL;
            default: r = RPT_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
(
    input  logic [7:0] a_sec,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hour,
    input  logic [7:0] a_day,
    input  logic [6:0] t_sec,
    input  logic [6:0] t_min,
    input  logic [6:0] t_hour,
    input  logic [2:0] t_wday,
    input  logic [5:0] t_date,
    output logic       hit
);

    rpt_e rpt;
    logic eq_s, eq_m, eq_h, eq_d;

    assign rpt  = decode_rpt({a_day[7], a_hour[7], a_min[7], a_sec[7]});
    assign eq_s = (t_sec  == a_sec[6:0]);
    assign eq_m = (t_min  == a_min[6:0]);
    assign eq_h = (t_hour == a_hour[6:0]);
    assign eq_d = a_day[6] ? (t_wday == a_day[2:0]) : (t_date == a_day[5:0]);

    always_comb begin
        unique case (rpt)
            RPT_EVERY: hit = 1'b1;
            RPT_S:     hit = eq_s;
            RPT_MS:    hit = eq_s & eq_m;
            RPT_HMS:   hit = eq_s & eq_m & eq_h;
            RPT_FULL:  hit = eq_s & eq_m & eq_h & eq_d;
            RPT_NONE:  hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen #(
    parameter int REF_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic [1:0] rate,
    output logic       wave
);

    localparam int CNT_W    = REF_LOG2 - 1;
    localparam int DIV4_BIT = 1;
    localparam int DIV8_BIT = 2;

    logic             ref_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic             slow_q;
    logic             sel;

    assign rise = ref_in & ~ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
            if (rise) begin
                cnt_q <= cnt_q + 1'b1;
                if (&cnt_q) slow_q <= ~slow_q;
            end
        end
    end

    always_comb begin
        unique case (rate)
            2'b00:   sel = slow_q;
            2'b01:   sel = cnt_q[DIV8_BIT];
            2'b10:   sel = cnt_q[DIV4_BIT];
            2'b11:   sel = ref_q;
            default: sel = ref_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave <= 1'b1;
        else        wave <= sel;
    end

endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
    import alarm_irq_pkg::*;
#(
    parameter int REF_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       ref_clk_in,
    input  logic [6:0] t_sec,
    input  logic [6:0] t_min,
    input  logic [6:0] t_hour,
    input  logic [2:0] t_wday,
    input  logic [5:0] t_date,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [1:0] alarm_flags,
    output logic       irq_a_oe,
    output logic       irq_b_oe
);

    localparam int N_AL = 2;

    logic [4:0]      ctrl_q;
    logic [7:0]      al_q [AL_REGS];
    logic [N_AL-1:0] flag_q;
    logic [N_AL-1:0] hit;
    logic [N_AL-1:0] ie;
    logic [1:0]      ctrl_rate;
    logic            ctrl_mode;
    logic            st_wr;
    logic            wave;

    assign ctrl_rate = ctrl_q[4:3];
    assign ctrl_mode = ctrl_q[2];
    assign ie        = ctrl_q[1:0];
    assign st_wr     = wr_en && (wr_addr == ADDR_STATUS);

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ctrl_q <= CTRL_RST;
        else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= wr_data[4:0];
    end

    // Alarm field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < AL_REGS; i++) al_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < AL_REGS; i++)
                if (wr_en && wr_addr == 4'(int'(ADDR_AL_BASE) + i))
                    al_q[i] <= wr_data;
        end
    end

    // Comparators: alarm B has no seconds field, so it sees 00 unmasked
    for (genvar g = 0; g < N_AL; g++) begin : g_alarm
        localparam int BASE = (g == 0) ? 0 : 3;
        alarm_match u_match (
            .a_sec  ((g == 0) ? al_q[0] : 8'h00),
            .a_min  (al_q[BASE+1]),
            .a_hour (al_q[BASE+2]),
            .a_day  (al_q[BASE+3]),
            .t_sec  (t_sec),
            .t_min  (t_min),
            .t_hour (t_hour),
            .t_wday (t_wday),
            .t_date (t_date),
            .hit    (hit[g])
        );
    end

    // Sticky flags: set wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < N_AL; i++)
                flag_q[i] <= (flag_q[i] & ~(st_wr & ~wr_data[i])) | (sec_tick & hit[i]);
        end
    end

    sqw_gen #(.REF_LOG2(REF_LOG2)) u_sqw (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_clk_in),
        .rate   (ctrl_rate),
        .wave   (wave)
    );

    // Output routing
    assign alarm_flags = flag_q;
    assign irq_a_oe    = ctrl_mode ? (flag_q[0] & ie[0]) : |(flag_q & ie);
    assign irq_b_oe    = ctrl_mode ? (flag_q[1] & ie[1]) : ~wave;

endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
    import alarm_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [1:0] alarm_flags,
    input logic       irq_a_oe,
    input logic       irq_b_oe,
    input logic       ctrl_mode
);

    logic clr_a, clr_b;
    assign clr_a = wr_en && wr_addr == ADDR_STATUS && !wr_data[0];
    assign clr_b = wr_en && wr_addr == ADDR_STATUS && !wr_data[1];

    AST_FLAG_A_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flags[0]) |-> $past(sec_tick)); // R2
    AST_FLAG_B_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flags[1]) |-> $past(sec_tick)); // R2
    AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flags[0] && !clr_a) |=> alarm_flags[0]); // R7
    AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flags[1] && !clr_b) |=> alarm_flags[1]); // R7
    AST_IRQ_A_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_oe |-> (alarm_flags != 2'b00)); // R8
    AST_IRQ_B_MODE1_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode && irq_b_oe) |-> alarm_flags[1]); // R9

endmodule

bind alarm_irq_router alarm_irq_chk u_chk (.*);

// File: tb/sim_alarm_irq_router.sv
`timescale 1ns/1ps
module sim_alarm_irq_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic [6:0] t_sec = '0, t_min = '0, t_hour = '0;
    logic [2:0] t_wday = '0;
    logic [5:0] t_date = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] alarm_flags;
    logic       irq_a_oe, irq_b_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;          // 250 MHz
    always #8 ref_clk_in = ~ref_clk_in;  // reference period = 4 clocks

    alarm_irq_router #(.REF_LOG2(6)) u0 (.*);

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input int act, input int exp, input string req);
        checks++;
        if (act < exp - 1 || act > exp + 1) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, m, h, input logic [2:0] wd, input logic [5:0] dt);
        t_sec = s; t_min = m; t_hour = h; t_wday = wd; t_date = dt;
    endtask

    task automatic tick(input logic [6:0] s, m, h, input logic [2:0] wd, input logic [5:0] dt);
        @(negedge clk); set_time(s, m, h, wd, dt); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic set_a(input logic [7:0] s, m, h, d);
        wr(4'd2, s); wr(4'd3, m); wr(4'd4, h); wr(4'd5, d);
    endtask

    task automatic set_b(input logic [7:0] m, h, d);
        wr(4'd6, m); wr(4'd7, h); wr(4'd8, d);
    endtask

    task automatic clear_flags();
        wr(4'd1, 8'h00);
    endtask

    task automatic count_b(output int n);
        logic prev;
        n = 0;
        prev = irq_b_oe;
        repeat (1024) begin
            @(negedge clk);
            if (irq_b_oe && !prev) n++;
            prev = irq_b_oe;
        end
    endtask

    task automatic t_reset();
        int n;
        chk(alarm_flags, 0, "R1 flags after reset");
        chk(irq_a_oe, 0, "R1 irq A released after reset");
        count_b(n);
        chk_rng(n, 256, "R1 reset rate is reference rate");
    endtask

    task automatic t_update_only();
        set_a(8'h80, 8'h80, 8'h80, 8'h80);
        @(negedge clk); set_time(7'h33, 7'h10, 7'h05, 3'd3, 6'h12);
        repeat (3) @(negedge clk);
        chk(alarm_flags, 0, "R2 no flag without strobe");
        tick(7'h33, 7'h10, 7'h05, 3'd3, 6'h12);
        chk(alarm_flags, 1, "R2 flag after strobe");
    endtask

    task automatic t_flag_write();
        wr(4'd1, 8'h03);
        chk(alarm_flags, 1, "R7 writing 1 keeps flag");
        wr(4'd1, 8'h02);
        chk(alarm_flags, 0, "R7 writing 0 clears flag");
        @(negedge clk);
        set_time(7'h01, 7'h02, 7'h03, 3'd1, 6'h01);
        sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h00;
        @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0;
        chk(alarm_flags, 1, "R7 match wins over clear");
        clear_flags();
    endtask

    task automatic t_alarm_a_modes();
        set_a(8'h25, 8'h80, 8'h80, 8'h80);
        tick(7'h24, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R3 seconds mismatch");
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 1, "R3 seconds match");
        clear_flags();
        set_a(8'h25, 8'h10, 8'h80, 8'h80);
        tick(7'h25, 7'h11, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R3 minute mismatch");
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 1, "R3 minute and second match");
        clear_flags();
        set_a(8'h25, 8'h10, 8'h14, 8'h80);
        tick(7'h25, 7'h10, 7'h15, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R3 hour mismatch");
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 1, "R3 hour minute second match");
        clear_flags();
        set_a(8'h25, 8'h10, 8'h52, 8'h80);
        tick(7'h25, 7'h10, 7'h12, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R12 hour format bit differs");
        tick(7'h25, 7'h10, 7'h52, 3'd5, 6'h15);
        chk(alarm_flags, 1, "R12 hour identical with format bits");
        clear_flags();
    endtask

    task automatic t_day_date();
        set_a(8'h25, 8'h10, 8'h14, 8'h15);
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h16);
        chk(alarm_flags, 0, "R6 date mismatch");
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 1, "R3 R6 full date match");
        clear_flags();
        set_a(8'h25, 8'h10, 8'h14, 8'h45);
        tick(7'h25, 7'h10, 7'h14, 3'd4, 6'h05);
        chk(alarm_flags, 0, "R6 weekday mismatch, date equals value");
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h01);
        chk(alarm_flags, 1, "R6 weekday match");
        clear_flags();
    endtask

    task automatic t_invalid();
        set_a(8'hA5, 8'h10, 8'h94, 8'h95);
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R5 alarm A pattern 1101 silent");
        set_a(8'h80, 8'h80, 8'h80, 8'h15);
        tick(7'h25, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R5 alarm A pattern 0111 silent");
        set_a(8'h00, 8'h00, 8'h00, 8'h00);
        set_b(8'h90, 8'h14, 8'h80);
        tick(7'h00, 7'h10, 7'h14, 3'd5, 6'h15);
        chk(alarm_flags, 0, "R5 alarm B pattern 101 silent");
    endtask

    task automatic t_alarm_b();
        set_b(8'h80, 8'h80, 8'h80);
        tick(7'h30, 7'h10, 7'h14, 3'd3, 6'h15);
        chk(alarm_flags, 0, "R4 alarm B quiet at nonzero second");
        tick(7'h00, 7'h10, 7'h14, 3'd3, 6'h15);
        chk(alarm_flags, 2, "R4 alarm B once per minute");
        clear_flags();
        set_b(8'h10, 8'h80, 8'h80);
        tick(7'h00, 7'h11, 7'h14, 3'd3, 6'h15);
        chk(alarm_flags, 0, "R4 alarm B minute mismatch");
        tick(7'h01, 7'h10, 7'h14, 3'd3, 6'h15);
        chk(alarm_flags, 0, "R4 alarm B minute match, second 01");
        tick(7'h00, 7'h10, 7'h14, 3'd3, 6'h15);
        chk(alarm_flags, 2, "R4 alarm B minute match");
        clear_flags();
        set_b(8'h10, 8'h14, 8'h43);
        tick(7'h00, 7'h10, 7'h14, 3'd2, 6'h03);
        chk(alarm_flags, 0, "R4 R6 alarm B weekday mismatch");
        tick(7'h00, 7'h10, 7'h14, 3'd3, 6'h09);
        chk(alarm_flags, 2, "R4 R6 alarm B full weekday match");
        clear_flags();
    endtask

    task automatic t_routing();
        set_a(8'h80, 8'h80, 8'h80, 8'h80);
        set_b(8'hFF, 8'hFF, 8'hFF);
        wr(4'd0, 8'h1F);
        tick(7'h05, 7'h01, 7'h01, 3'd1, 6'h01);
        chk(alarm_flags, 1, "R9 only A flagged");
        chk(irq_a_oe, 1, "R9 A drives output A");
        chk(irq_b_oe, 0, "R9 output B idle");
        clear_flags();
        set_a(8'h00, 8'h00, 8'h00, 8'h00);
        set_b(8'h80, 8'h80, 8'h80);
        tick(7'h00, 7'h01, 7'h01, 3'd1, 6'h01);
        chk(irq_a_oe, 0, "R9 B flag does not drive A");
        chk(irq_b_oe, 1, "R9 B drives output B");
        set_a(8'h80, 8'h80, 8'h80, 8'h80);
        tick(7'h00, 7'h01, 7'h01, 3'd1, 6'h01);
        chk(alarm_flags, 3, "R8 both flags set");
        wr(4'd0, 8'h1C);
        chk(irq_a_oe, 0, "R8 A disabled");
        chk(irq_b_oe, 0, "R8 B disabled");
        wr(4'd0, 8'h1A);
        chk(irq_a_oe, 1, "R10 B flag shares output A");
        wr(4'd0, 8'h18);
        chk(irq_a_oe, 0, "R8 shared output needs enable");
        wr(4'd0, 8'h19);
        chk(irq_a_oe, 1, "R10 A flag shares output A");
        set_a(8'h00, 8'h00, 8'h00, 8'h00);
        set_b(8'hFF, 8'hFF, 8'hFF);
        clear_flags();
        chk(irq_a_oe, 0, "R10 output A released after clear");
    endtask

    task automatic t_rates();
        int n;
        wr(4'd0, 8'h10);
        repeat (300) @(negedge clk);
        count_b(n);
        chk_rng(n, 64, "R11 R10 code 10 quarter rate");
        wr(4'd0, 8'h08);
        repeat (300) @(negedge clk);
        count_b(n);
        chk_rng(n, 32, "R11 code 01 eighth rate");
        wr(4'd0, 8'h00);
        repeat (600) @(negedge clk);
        count_b(n);
        chk_rng(n, 4, "R11 code 00 slowest rate");
        wr(4'd0, 8'h18);
        repeat (20) @(negedge clk);
        count_b(n);
        chk_rng(n, 256, "R11 code 11 reference rate");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_update_only();
        t_flag_write();
        t_alarm_a_modes();
        t_day_date();
        t_invalid();
        t_alarm_b();
        t_routing();
        t_rates();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule